// File: doc/BRIEF.md
# AES Register Front-End

This block is the byte-wide register window between a host bus and a separate AES-128 cipher engine. A host reaches it through single-byte reads and writes in a 19-byte address window. The window holds a control register, which is reachable at two addresses, and one 16-byte page range. That page range is steered by a mode field to either the key page or the data (state) page. The block holds the operands, starts the engine through a start/accept handshake, and captures the cipher output and the final round key when the engine reports done.

The host reads back the final round key of the last operation through the key page. The key the host wrote stays hidden and is presented to the engine again for each later run. A sleep input blocks all host access and wipes every register.

Top module: `aes_reg_front`

## Requirements
- R1: Only addresses 0x82..0x94 are decoded. Writes outside the window are ignored and reads outside it return 0. Address 0x82 is in the window, but it reads 0 and ignores writes.
- R2: The control byte is at 0x83 and also at 0x94. Both addresses read and write the same register. Its fields are: bit0 request, bit1 direction, bits[4:2] mode, bit7 done. Bits 6:5 read 0.
- R3: Addresses 0x84..0x93 reach the key page when mode=1 and the data page when mode=0. With any other mode value, those addresses read 0 and writes to them change neither page.
- R4: Address 0x84 is the most significant byte of the 128-bit key and data vectors, and 0x93 is the least significant byte.
- R5: Writing 1 to bit0 raises engStart, which stays high until the cycle engAccept is sampled. The request bit then clears on the next edge. A burst write over 0x83..0x94 can set the mode, load all 16 bytes, and issue the request.
- R6: The done bit sets on the edge that samples engDone during an operation. It clears on the edge that accepts a new request.
- R7: Key page reads return the last round key captured from the engine, which is 0 after reset. The written key is never read back.
- R8: The written key is held and driven on engKey unchanged across operations, so it serves every later run.
- R9: When engDone is sampled, the data page takes engResult.
- R10: From a request until engDone, writes to both pages and new requests are ignored.
- R11: While sleepIn is high, writes have no effect and all reads return 0. Sleep or reset clears the control fields, both pages and both keys.
- R12: engDecrypt follows the direction bit, where 1 means decrypt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepIn | input | 1 | Sleep: blocks access and clears state |
| hostAddr | input | 8 | Host byte address |
| hostWe | input | 1 | Host write enable |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational on address) |
| engStart | output | 1 | Operation request to engine |
| engDecrypt | output | 1 | Direction to engine, 1 = decrypt |
| engKey | output | 128 | Initial key held for the engine |
| engData | output | 128 | Data block held for the engine |
| engAccept | input | 1 | Engine takes the request |
| engDone | input | 1 | Engine result valid |
| engResult | input | 128 | Cipher output block |
| engRoundKey | input | 128 | Final round key of the operation |

## Verification
Two collisions are provoked on purpose. In the first, the engine's done pulse arrives in the same cycle as a host control write that changes the mode. The check is that the done bit sets, the new mode lands and the captured result is readable through the new mode. In the second, sleep is raised in the same cycle as the done pulse. The check is that the wipe wins: after wake-up the control byte, both pages and engKey read as zero.

// File: rtl/aes_front_pkg.sv
package aes_front_pkg;
  localparam int NBYTES    = 16;
  localparam int BLK_W     = NBYTES * 8;
  localparam int IDX_W     = $clog2(NBYTES);
  localparam int MODE_W    = 3;
  localparam logic [7:0] WIN_LO   = 8'h82;
  localparam logic [7:0] CTRL_A   = 8'h83;
  localparam logic [7:0] PAGE_LO  = 8'h84;
  localparam logic [7:0] PAGE_HI  = PAGE_LO + 8'(NBYTES - 1);
  localparam logic [7:0] MIRROR_A = PAGE_HI + 8'd1;
  localparam logic [MODE_W-1:0] MODE_ECB = 3'd0;
  localparam logic [MODE_W-1:0] MODE_KEY = 3'd1;

  typedef struct packed {
    logic             keyWe;
    logic             stateWe;
    logic [IDX_W-1:0] byteIdx;
    logic [7:0]       wrByte;
    logic             capture;
    logic             wipe;
  } strobes_t;
endpackage

// File: rtl/aes_front_ctrl.sv
module aes_front_ctrl
  import aes_front_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepIn,
  input  logic [7:0] hostAddr,
  input  logic       hostWe,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic [7:0] keyRdByte,
  input  logic [7:0] stateRdByte,
  output strobes_t   st,
  output logic       engStart,
  output logic       engDecrypt,
  input  logic       engAccept,
  input  logic       engDone
);
  logic             reqBit, busyBit, doneBit, dirBit;
  logic [MODE_W-1:0] modeFld;
  logic inWin, isCtrl, isPage, awake, inProg, ctrlWe;
  logic [7:0] pageOff;

  assign awake   = !sleepIn;
  assign inWin   = (hostAddr >= WIN_LO) && (hostAddr <= MIRROR_A);
  assign isCtrl  = (hostAddr == CTRL_A) || (hostAddr == MIRROR_A);
  assign isPage  = (hostAddr >= PAGE_LO) && (hostAddr <= PAGE_HI);
  assign pageOff = hostAddr - PAGE_LO;
  assign inProg  = reqBit || busyBit;
  assign ctrlWe  = hostWe && awake && isCtrl;

  always_comb begin
    st.byteIdx = pageOff[IDX_W-1:0];
    st.wrByte  = hostWdata;
    st.keyWe   = hostWe && awake && isPage && !inProg && (modeFld == MODE_KEY);
    st.stateWe = hostWe && awake && isPage && !inProg && (modeFld == MODE_ECB);
    st.capture = engDone && busyBit && awake;
    st.wipe    = sleepIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBit <= 1'b0; busyBit <= 1'b0; doneBit <= 1'b0;
      dirBit <= 1'b0; modeFld <= '0;
    end else if (sleepIn) begin
      reqBit <= 1'b0; busyBit <= 1'b0; doneBit <= 1'b0;
      dirBit <= 1'b0; modeFld <= '0;
    end else begin
      if (reqBit && engAccept) begin
        reqBit  <= 1'b0;
        busyBit <= 1'b1;
      end
      if (st.capture) begin
        busyBit <= 1'b0;
        doneBit <= 1'b1;
      end
      if (ctrlWe) begin
        modeFld <= hostWdata[4:2];
        dirBit  <= hostWdata[1];
        if (hostWdata[0] && !inProg) begin
          reqBit  <= 1'b1;
          doneBit <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    hostRdata = 8'h00;
    if (awake && inWin) begin
      if (isCtrl)
        hostRdata = {doneBit, 2'b00, modeFld, dirBit, reqBit};
      else if (isPage && modeFld == MODE_KEY)
        hostRdata = keyRdByte;
      else if (isPage && modeFld == MODE_ECB)
        hostRdata = stateRdByte;
    end
  end

  assign engStart   = reqBit;
  assign engDecrypt = dirBit;
endmodule

// File: rtl/aes_front_dpath.sv
module aes_front_dpath
  import aes_front_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic [BLK_W-1:0] engResult,
  input  logic [BLK_W-1:0] engRoundKey,
  output logic [BLK_W-1:0] engKey,
  output logic [BLK_W-1:0] engData,
  output logic [7:0]       keyRdByte,
  output logic [7:0]       stateRdByte
);
  logic [BLK_W-1:0] initKey, lastKey, stateReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initKey <= '0; lastKey <= '0; stateReg <= '0;
    end else if (st.wipe) begin
      initKey <= '0; lastKey <= '0; stateReg <= '0;
    end else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (st.keyWe && st.byteIdx == IDX_W'(b))
          initKey[BLK_W-1-8*b -: 8] <= st.wrByte;
        if (st.stateWe && st.byteIdx == IDX_W'(b))
          stateReg[BLK_W-1-8*b -: 8] <= st.wrByte;
      end
      if (st.capture) begin
        stateReg <= engResult;
        lastKey  <= engRoundKey;
      end
    end
  end

  assign keyRdByte   = lastKey[BLK_W-1-8*int'(st.byteIdx) -: 8];
  assign stateRdByte = stateReg[BLK_W-1-8*int'(st.byteIdx) -: 8];
  assign engKey      = initKey;
  assign engData     = stateReg;
endmodule

// File: rtl/aes_reg_front.sv
module aes_reg_front
  import aes_front_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepIn,
  input  logic [7:0]       hostAddr,
  input  logic             hostWe,
  input  logic [7:0]       hostWdata,
  output logic [7:0]       hostRdata,
  output logic             engStart,
  output logic             engDecrypt,
  output logic [BLK_W-1:0] engKey,
  output logic [BLK_W-1:0] engData,
  input  logic             engAccept,
  input  logic             engDone,
  input  logic [BLK_W-1:0] engResult,
  input  logic [BLK_W-1:0] engRoundKey
);
  strobes_t   st;
  logic [7:0] keyRdByte, stateRdByte;

  aes_front_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .keyRdByte(keyRdByte), .stateRdByte(stateRdByte),
    .st(st), .engStart(engStart), .engDecrypt(engDecrypt),
    .engAccept(engAccept), .engDone(engDone)
  );

  aes_front_dpath u_dpath (
    .clk(clk), .rstN(rstN), .st(st),
    .engResult(engResult), .engRoundKey(engRoundKey),
    .engKey(engKey), .engData(engData),
    .keyRdByte(keyRdByte), .stateRdByte(stateRdByte)
  );
endmodule

// File: rtl/aes_reg_front_chk.sv
module aes_reg_front_chk
  import aes_front_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sleepIn,
  input logic [7:0]       hostAddr,
  input logic [7:0]       hostRdata,
  input logic             engStart,
  input logic             engAccept,
  input logic [BLK_W-1:0] engKey,
  input logic [BLK_W-1:0] engData
);
  // R1
  window_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr < WIN_LO || hostAddr > MIRROR_A) |-> hostRdata == 8'h00);
  // R11
  sleep_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |-> hostRdata == 8'h00);
  // R11
  sleep_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |=> !engStart);
  // R5
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !engAccept && !sleepIn) |=> engStart);
  // R5
  start_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engAccept) |=> !engStart);
  // R10
  operand_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !engAccept && !sleepIn) |=> ($stable(engData) && $stable(engKey)));
endmodule

bind aes_reg_front aes_reg_front_chk u_chk (
  .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .hostAddr(hostAddr),
  .hostRdata(hostRdata), .engStart(engStart), .engAccept(engAccept),
  .engKey(engKey), .engData(engData)
);

// File: tb/aes_reg_front_bench.sv
`timescale 1ns/1ps
module aes_reg_front_bench;
  logic clk = 0, rstN = 0, sleepIn = 0;
  logic [7:0] hostAddr = 0, hostWdata = 0, hostRdata;
  logic hostWe = 0, engStart, engDecrypt, engAccept = 0, engDone = 0;
  logic [127:0] engKey, engData, engResult = 0, engRoundKey = 0;
  int total = 0, bad = 0;
  logic [127:0] keyVec, datVec, resVec, rkVec;

  always #4 clk = ~clk;

  aes_reg_front u_aes_reg_front (.*);

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWe = 1; hostWdata = d;
    @(negedge clk); hostWe = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    hostAddr = a; #1; d = hostRdata;
  endtask

  // engine accept: waits for start, samples operands on the accept cycle
  task automatic accept(output logic [127:0] k, output logic [127:0] dt, output logic dir);
    @(negedge clk);
    while (!engStart) @(negedge clk);
    engAccept = 1; k = engKey; dt = engData; dir = engDecrypt;
    @(negedge clk); engAccept = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(8'h83, v); check("R2 reset ctrl", 128'(v), 0);
    rd(8'h84, v); check("R11 reset data page", 128'(v), 0);
    check("R5 reset start", 128'(engStart), 0);
  endtask

  task automatic t_window;
    logic [7:0] v;
    wr(8'h80, 8'h5A); wr(8'h95, 8'h3C); wr(8'h82, 8'h77);
    rd(8'h80, v); check("R1 below window", 128'(v), 0);
    rd(8'h95, v); check("R1 above window", 128'(v), 0);
    rd(8'h82, v); check("R1 reserved 0x82", 128'(v), 0);
    rd(8'h83, v); check("R1 ctrl untouched", 128'(v), 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    wr(8'h83, 8'hE6);
    rd(8'h83, v); check("R2 ctrl fields", 128'(v), 128'h06);
    rd(8'h94, v); check("R2 mirror read", 128'(v), 128'h06);
    check("R12 dir drives decrypt", 128'(engDecrypt), 1);
    wr(8'h94, 8'h00);
    rd(8'h83, v); check("R2 mirror write", 128'(v), 0);
  endtask

  task automatic t_key_load;
    logic [7:0] v;
    wr(8'h83, 8'h04);
    for (int i = 0; i < 16; i++) wr(8'h84 + 8'(i), keyVec[127-8*i -: 8]);
    wr(8'h94, 8'h04);
    check("R4 key byte order", engKey, keyVec);
    rd(8'h84, v); check("R7 written key hidden", 128'(v), 0);
    wr(8'h83, 8'h0C); wr(8'h84, 8'hEE);
    rd(8'h84, v); check("R3 other mode reads 0", 128'(v), 0);
    check("R3 other mode key intact", engKey, keyVec);
    check("R3 other mode data intact", engData, 0);
  endtask

  task automatic t_ecb;
    logic [7:0] v; logic [127:0] k, dt; logic dir;
    wr(8'h83, 8'h00);
    for (int i = 0; i < 16; i++) wr(8'h84 + 8'(i), datVec[127-8*i -: 8]);
    check("R4 data msb at 0x84", 128'(engData[127:120]), 128'(datVec[127:120]));
    check("R4 data lsb at 0x93", 128'(engData[7:0]), 128'(datVec[7:0]));
    wr(8'h94, 8'h01);
    check("R5 start raised", 128'(engStart), 1);
    wr(8'h84, 8'hFF);
    rd(8'h84, v); check("R10 pending page write", 128'(v), 128'(datVec[127:120]));
    accept(k, dt, dir);
    check("R8 key to engine", k, keyVec);
    check("R5 data to engine", dt, datVec);
    check("R12 encrypt dir", 128'(dir), 0);
    check("R5 start self-clear", 128'(engStart), 0);
    wr(8'h85, 8'h11);
    wr(8'h94, 8'h01);
    check("R10 request ignored busy", 128'(engStart), 0);
    check("R10 busy page write", engData, datVec);
    // collision: done pulse with a control write changing mode to key page
    @(negedge clk);
    engDone = 1; engResult = resVec; engRoundKey = rkVec;
    hostAddr = 8'h83; hostWe = 1; hostWdata = 8'h04;
    @(negedge clk); engDone = 0; hostWe = 0;
    rd(8'h83, v); check("R6 done set with ctrl write", 128'(v), 128'h84);
    rd(8'h84, v); check("R7 round key msb", 128'(v), 128'(rkVec[127:120]));
    rd(8'h93, v); check("R7 round key lsb", 128'(v), 128'(rkVec[7:0]));
    check("R8 initial key kept", engKey, keyVec);
    wr(8'h83, 8'h00);
    check("R9 result captured", engData, resVec);
    rd(8'h84, v); check("R9 result readable", 128'(v), 128'(resVec[127:120]));
  endtask

  task automatic t_decrypt;
    logic [7:0] v; logic [127:0] k, dt; logic dir;
    wr(8'h83, 8'h03);
    rd(8'h83, v); check("R6 done cleared by request", 128'(v), 128'h03);
    accept(k, dt, dir);
    check("R12 decrypt dir", 128'(dir), 1);
    check("R8 key reused", k, keyVec);
    check("R5 operands are last result", dt, resVec);
  endtask

  task automatic t_sleep;
    logic [7:0] v;
    // collision: sleep entry in the done cycle, wipe must win
    @(negedge clk);
    sleepIn = 1; engDone = 1; engResult = ~resVec; engRoundKey = ~rkVec;
    @(negedge clk); engDone = 0;
    rd(8'h83, v); check("R11 sleep read zero", 128'(v), 0);
    wr(8'h83, 8'h05);
    sleepIn = 0;
    @(negedge clk);
    rd(8'h83, v); check("R11 ctrl cleared, sleep write ignored", 128'(v), 0);
    check("R11 data wiped", engData, 0);
    check("R11 key wiped", engKey, 0);
    check("R11 start low", 128'(engStart), 0);
    wr(8'h83, 8'h04);
    rd(8'h84, v); check("R11 round key wiped", 128'(v), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      keyVec[127-8*i -: 8] = 8'h10 + 8'(i);
      datVec[127-8*i -: 8] = 8'hC0 + 8'(i);
      resVec[127-8*i -: 8] = 8'h30 + 8'(3*i);
      rkVec[127-8*i -: 8]  = 8'h90 + 8'(5*i);
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_ctrl();
    t_key_load();
    t_ecb();
    t_decrypt();
    t_sleep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule